// File: doc/BRIEF.md
# Byte Parity Generator and Checker

This block sits between a 16-bit bus data latch and a memory array. On the write side it adds one parity bit to each byte of the word. It passes the data, the two parity bits and a per-byte write enable to the array, one clock after the write request. On the read side it takes the 16 data bits and 2 parity bits that the array returns. It checks each byte against its parity bit and latches the word so that it can be presented to the bus.

Stored parity is normally odd. A diagnostic control inverts the parity sense on writes, on full-word and byte writes alike, so that software can plant bad parity and later confirm that the checker flags it. A checked read that fails gives a one-cycle error strobe and a per-byte failure map, which are meant for a status register. It also raises a bus-level parity-error flag, but only when the indication enable is set. That flag stays up, and the read word stays on the bus, until the bus cycle signal drops.

Top module: `bpar_unit`

## Requirements
- R1: One clock after a sampled `wr_valid_i` with `wrong_par_i` low, each written lane l (bits 8l+7..8l) appears on `arr_wdata_o` with `arr_wpar_o[l]` chosen so that the 8 data bits plus the parity bit hold an odd number of ones.
- R2: With `wrong_par_i` high at the write, each written lane stores even parity instead: the 8 data bits plus the parity bit hold an even number of ones.
- R3: `arr_we_o` is `wr_be_i` (bit 0 = low byte, bit 1 = high byte) for the one clock after a sampled write, and is 0 otherwise. The data and parity outputs of a lane whose enable is 0 keep their previous values. R1 and R2 apply to byte writes as well.
- R4: A read is taken when `rd_valid_i` and `cycle_i` are both high at a clock edge. Lane l fails when its 8 array data bits plus `arr_rpar_i[l]` hold an even number of ones. One clock after the read, `err_lane_o` bit l is 1 for each failing lane and `err_pulse_o` is high for exactly one clock if any lane failed.
- R5: Without a taken read (`rd_valid_i` low, or `cycle_i` low), array read inputs cause no error strobe, no bus flag and no change of `rd_data_o`.
- R6: `bus_perr_o` rises one clock after a failing read only when `err_en_i` was high at that read. It stays high while `cycle_i` stays high and falls one clock after `cycle_i` is sampled low.
- R7: `rd_data_o` takes the array word one clock after a taken read, and `rd_drive_o` goes high at the same time. The word is held unchanged until the next taken read. `rd_drive_o` falls one clock after `cycle_i` is sampled low.
- R8: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request from the bus latch |
| wr_data_i | input | 16 | Write word |
| wr_be_i | input | 2 | Byte enables of the write (bit 0 low byte) |
| wrong_par_i | input | 1 | Diagnostic control: store even parity |
| arr_wdata_o | output | 16 | Data to the array |
| arr_wpar_o | output | 2 | Parity bits to the array, one per byte |
| arr_we_o | output | 2 | Per-byte write strobe to the array |
| cycle_i | input | 1 | Bus master sync: current bus cycle active |
| rd_valid_i | input | 1 | Array read data has settled |
| arr_rdata_i | input | 16 | Data from the array |
| arr_rpar_i | input | 2 | Parity bits from the array |
| err_en_i | input | 1 | Error-indication enable for the bus flag |
| rd_data_o | output | 16 | Latched read word for the bus |
| rd_drive_o | output | 1 | Read word is being presented to the bus |
| err_pulse_o | output | 1 | One-clock read parity error strobe |
| err_lane_o | output | 2 | Failing lanes of the last taken read |
| bus_perr_o | output | 1 | Bus parity-error flag, held to end of cycle |

## Verification
Every value of a byte is written in both lanes. Each lane carries a different byte, so a swap of lanes or a parity bit on the wrong byte shows up. The same values are then written with the diagnostic inversion, which separates odd from even generation. Byte writes with each enable, in both parity modes, show whether the idle lane keeps its data and parity. Reads cover every byte value with all four parity-bit patterns and both enable settings, which separates the per-lane check, the strobe and the gating of the bus flag. Reads without valid data, and with valid data outside a bus cycle, show that nothing is taken then.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_HOLD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/bpar_gen.sv
module bpar_gen #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic         invert_i,
    output logic         par_o
);
    // odd parity by default; invert_i flips to even
    always_comb begin
        par_o = ~(^data_i) ^ invert_i;
    end
endmodule

// File: rtl/bpar_check.sv
module bpar_check #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic         par_i,
    output logic         bad_o
);
    // a good lane holds an odd count of ones over data and parity
    always_comb begin
        bad_o = ~(^{data_i, par_i});
    end
endmodule

// File: rtl/bpar_unit.sv
module bpar_unit
    import bpar_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = BYTE_W
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_valid_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [DATA_W/LANE_W-1:0] wr_be_i,
    input  logic                     wrong_par_i,
    output logic [DATA_W-1:0]        arr_wdata_o,
    output logic [DATA_W/LANE_W-1:0] arr_wpar_o,
    output logic [DATA_W/LANE_W-1:0] arr_we_o,
    input  logic                     cycle_i,
    input  logic                     rd_valid_i,
    input  logic [DATA_W-1:0]        arr_rdata_i,
    input  logic [DATA_W/LANE_W-1:0] arr_rpar_i,
    input  logic                     err_en_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic                     rd_drive_o,
    output logic                     err_pulse_o,
    output logic [DATA_W/LANE_W-1:0] err_lane_o,
    output logic                     bus_perr_o
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  wpar;
        logic [LANES-1:0]  we;
        logic [DATA_W-1:0] rdata;
        rd_state_e         rstate;
        logic              pulse;
        logic [LANES-1:0]  elane;
        logic              perr;
    } regs_t;

    regs_t q, d;

    logic [LANES-1:0] gen_par;
    logic [LANES-1:0] lane_bad;
    logic             rd_take;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bpar_gen #(.W(LANE_W)) i_gen (
            .data_i   (wr_data_i[l*LANE_W +: LANE_W]),
            .invert_i (wrong_par_i),
            .par_o    (gen_par[l])
        );
        bpar_check #(.W(LANE_W)) i_check (
            .data_i (arr_rdata_i[l*LANE_W +: LANE_W]),
            .par_i  (arr_rpar_i[l]),
            .bad_o  (lane_bad[l])
        );
    end

    always_comb begin
        d       = q;
        d.we    = '0;
        d.pulse = 1'b0;
        rd_take = rd_valid_i && cycle_i;

        for (int l = 0; l < LANES; l++) begin
            if (wr_valid_i && wr_be_i[l]) begin
                d.wdata[l*LANE_W +: LANE_W] = wr_data_i[l*LANE_W +: LANE_W];
                d.wpar[l]                   = gen_par[l];
                d.we[l]                     = 1'b1;
            end
        end

        if (rd_take) begin
            d.rdata  = arr_rdata_i;
            d.rstate = RD_HOLD;
            d.pulse  = |lane_bad;
            d.elane  = lane_bad;
            if (err_en_i && (|lane_bad)) begin
                d.perr = 1'b1;
            end
        end else if (!cycle_i) begin
            d.rstate = RD_IDLE;
            d.perr   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign arr_wdata_o = q.wdata;
    assign arr_wpar_o  = q.wpar;
    assign arr_we_o    = q.we;
    assign rd_data_o   = q.rdata;
    assign rd_drive_o  = (q.rstate == RD_HOLD);
    assign err_pulse_o = q.pulse;
    assign err_lane_o  = q.elane;
    assign bus_perr_o  = q.perr;
endmodule

// File: rtl/bpar_unit_sva.sv
module bpar_unit_sva #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     wr_valid_i,
    input logic [DATA_W/LANE_W-1:0] wr_be_i,
    input logic                     wrong_par_i,
    input logic [DATA_W-1:0]        arr_wdata_o,
    input logic [DATA_W/LANE_W-1:0] arr_wpar_o,
    input logic [DATA_W/LANE_W-1:0] arr_we_o,
    input logic                     cycle_i,
    input logic                     rd_valid_i,
    input logic                     err_en_i,
    input logic [DATA_W-1:0]        rd_data_o,
    input logic                     rd_drive_o,
    input logic                     err_pulse_o,
    input logic                     bus_perr_o
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // R1 and R2: stored lane parity follows the diagnostic control at write time
        p_lane_sense_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            arr_we_o[l] |-> ((^{arr_wdata_o[l*LANE_W +: LANE_W], arr_wpar_o[l]}) == !$past(wrong_par_i)));
        // R3: an idle lane keeps its data and parity
        p_idle_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !arr_we_o[l] |-> ($stable(arr_wdata_o[l*LANE_W +: LANE_W]) && $stable(arr_wpar_o[l])));
    end

    // R3: strobes only follow a write request with matching enables
    p_we_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arr_we_o != '0) |-> ($past(wr_valid_i) && (arr_we_o == $past(wr_be_i))));

    // R4, R5: error strobe only after a taken read
    p_pulse_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_pulse_o |-> $past(rd_valid_i && cycle_i));

    // R6: bus flag rises only with the enable set at the read
    p_flag_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_perr_o) |-> $past(err_en_i && rd_valid_i && cycle_i));

    // R6: the flag ends with the bus cycle
    p_flag_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cycle_i |=> !bus_perr_o);

    // R7: drive ends with the bus cycle, and the held word is stable without a new read
    p_drive_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cycle_i |=> !rd_drive_o);
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_valid_i && cycle_i) |=> $stable(rd_data_o));
endmodule

bind bpar_unit bpar_unit_sva #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_bpar_unit_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_be_i     (wr_be_i),
    .wrong_par_i (wrong_par_i),
    .arr_wdata_o (arr_wdata_o),
    .arr_wpar_o  (arr_wpar_o),
    .arr_we_o    (arr_we_o),
    .cycle_i     (cycle_i),
    .rd_valid_i  (rd_valid_i),
    .err_en_i    (err_en_i),
    .rd_data_o   (rd_data_o),
    .rd_drive_o  (rd_drive_o),
    .err_pulse_o (err_pulse_o),
    .bus_perr_o  (bus_perr_o)
);

// File: tb/test_bpar_unit.sv
module test_bpar_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [1:0]  wr_be_i = '0;
    logic        wrong_par_i = 1'b0;
    logic [15:0] arr_wdata_o;
    logic [1:0]  arr_wpar_o;
    logic [1:0]  arr_we_o;
    logic        cycle_i = 1'b0;
    logic        rd_valid_i = 1'b0;
    logic [15:0] arr_rdata_i = '0;
    logic [1:0]  arr_rpar_i = '0;
    logic        err_en_i = 1'b0;
    logic [15:0] rd_data_o;
    logic        rd_drive_o;
    logic        err_pulse_o;
    logic [1:0]  err_lane_o;
    logic        bus_perr_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bpar_unit i_bpar_unit (.*);

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    function automatic logic odd_bit(input logic [7:0] b);
        int n = 0;
        for (int k = 0; k < 8; k++) n += int'(b[k]);
        return (n % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] data, input logic [1:0] be, input logic wrong,
                            input string req);
        logic [15:0] prev_d = arr_wdata_o;
        logic [1:0]  prev_p = arr_wpar_o;
        logic [15:0] exp_d;
        logic [1:0]  exp_p;
        @(negedge clk_i);
        wr_valid_i = 1'b1; wr_data_i = data; wr_be_i = be; wrong_par_i = wrong;
        @(negedge clk_i);
        wr_valid_i = 1'b0; wr_be_i = '0; wrong_par_i = 1'b0;
        exp_d = prev_d; exp_p = prev_p;
        for (int l = 0; l < 2; l++) begin
            if (be[l]) begin
                exp_d[l*8 +: 8] = data[l*8 +: 8];
                exp_p[l] = odd_bit(data[l*8 +: 8]) ^ wrong;
            end
        end
        chk(req, "write data", 32'(arr_wdata_o), 32'(exp_d));
        chk(req, "write parity", 32'(arr_wpar_o), 32'(exp_p));
        chk("R3", "write strobe", 32'(arr_we_o), 32'(be));
    endtask

    task automatic do_read(input logic [15:0] data, input logic [1:0] par, input logic en);
        logic [1:0] bad;
        bad[0] = (par[0] != odd_bit(data[7:0]));
        bad[1] = (par[1] != odd_bit(data[15:8]));
        @(negedge clk_i);
        cycle_i = 1'b1; rd_valid_i = 1'b1; arr_rdata_i = data; arr_rpar_i = par; err_en_i = en;
        @(negedge clk_i);
        rd_valid_i = 1'b0; arr_rdata_i = ~data; arr_rpar_i = ~par; err_en_i = 1'b0;
        chk("R4", "error strobe", 32'(err_pulse_o), 32'(bad != 2'b00));
        chk("R4", "error lanes", 32'(err_lane_o), 32'(bad));
        chk("R6", "bus flag set", 32'(bus_perr_o), 32'(en && bad != 2'b00));
        chk("R7", "read word", 32'(rd_data_o), 32'(data));
        chk("R7", "drive on", 32'(rd_drive_o), 32'd1);
        @(negedge clk_i);
        chk("R4", "strobe one clock", 32'(err_pulse_o), 32'd0);
        chk("R6", "bus flag held", 32'(bus_perr_o), 32'(en && bad != 2'b00));
        chk("R7", "word held", 32'(rd_data_o), 32'(data));
        cycle_i = 1'b0;
        @(negedge clk_i);
        chk("R6", "bus flag cleared", 32'(bus_perr_o), 32'd0);
        chk("R7", "drive off", 32'(rd_drive_o), 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk_i);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk_i);
        // R8: reset state
        chk("R8", "wdata", 32'(arr_wdata_o), 0);
        chk("R8", "wpar/we", 32'({arr_wpar_o, arr_we_o}), 0);
        chk("R8", "read side", 32'({rd_data_o, rd_drive_o, err_pulse_o, err_lane_o, bus_perr_o}), 0);
        rst_ni = 1'b1;

        // R1: odd parity, every byte value in each lane
        for (int i = 0; i < 256; i++) do_write({8'(255 - i), 8'(i)}, 2'b11, 1'b0, "R1");
        // R2: inverted sense
        for (int i = 0; i < 256; i += 3) do_write({8'(i), 8'(i * 7)}, 2'b11, 1'b1, "R2");
        // R3: byte writes in both modes, idle lane kept
        for (int i = 0; i < 256; i += 5) begin
            do_write(16'({8'(i), 8'(i ^ 8'h5a)}), 2'b01, i[0], "R3");
            do_write(16'({8'(i + 1), 8'(i)}), 2'b10, i[1], "R3");
        end
        @(negedge clk_i);
        chk("R3", "no strobe when idle", 32'(arr_we_o), 0);

        // R4, R6, R7: every byte value, all parity patterns, both enables
        for (int i = 0; i < 256; i++) begin
            for (int p = 0; p < 4; p++) do_read({~8'(i), 8'(i)}, 2'(p), i[1] ^ p[0]);
        end

        // R5: bad data without valid, and valid outside a cycle
        held = rd_data_o;
        @(negedge clk_i);
        cycle_i = 1'b1; err_en_i = 1'b1; arr_rdata_i = 16'h0000; arr_rpar_i = 2'b00;
        @(negedge clk_i);
        chk("R5", "no strobe without valid", 32'(err_pulse_o), 0);
        chk("R5", "no flag without valid", 32'(bus_perr_o), 0);
        chk("R5", "word unchanged", 32'(rd_data_o), 32'(held));
        cycle_i = 1'b0; rd_valid_i = 1'b1;
        @(negedge clk_i);
        rd_valid_i = 1'b0; err_en_i = 1'b0;
        chk("R5", "no strobe outside cycle", 32'(err_pulse_o), 0);
        chk("R5", "no flag outside cycle", 32'(bus_perr_o), 0);
        chk("R5", "word unchanged outside cycle", 32'(rd_data_o), 32'(held));
        chk("R5", "no drive outside cycle", 32'(rd_drive_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule